// File: doc/BRIEF.md
# I2C Command and Receive FIFO Pair

This block holds the two queues between a processor and an I2C bus engine. Processor writes push 9-bit commands (an 8-bit data byte plus a read/write command bit) into a transmit queue, and the engine pops them in order. The engine pushes received bytes into a receive queue, and processor reads pop them. Both queues export their fill level so that an interrupt block can compare them against thresholds.

Three misuse cases raise single-cycle event pulses for the interrupt block to latch. A read from an empty receive queue raises one. A received byte that finds the receive queue full raises one, and the byte is dropped. A command write into a full transmit queue raises one, and the command is dropped. An optional hold mode replaces receive overflow with a stall request to the engine. A transmit abort empties both queues and keeps them locked empty until the abort-clear strobe arrives. Deasserting the enable input also keeps both queues flushed.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset both levels are 0, the three event outputs are 0, `eng_stall_o` is 0 and `eng_cmd_valid_o` is 0.
- R2: Commands leave the transmit queue on `eng_cmd_o` in write order, with bit 8 the read/write command bit and bits 7:0 the data. `eng_cmd_valid_o` is high exactly when the queue holds an entry and no flush is in force. Received bytes appear on `cpu_rd_data_o` in push order, showing the oldest byte.
- R3: Levels range from 0 to DEPTH inclusive and change one cycle after the strobe. A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged.
- R4: A processor read while the receive queue is empty, or while a flush is in force, pulses `rx_under_o` for one cycle, in the cycle after the read.
- R5: With hold mode off, an engine push into a full receive queue pulses `rx_over_o` in the next cycle. The byte is dropped and the stored bytes are kept. A push into a full queue is refused even when a pop occurs in the same cycle.
- R6: With hold mode on, `eng_stall_o` is high while enabled and the receive queue is full, and `rx_over_o` never pulses. A push into the full queue is still dropped.
- R7: A processor command write into a full transmit queue pulses `tx_over_o` in the next cycle, and the command is dropped.
- R8: An `abort_i` cycle empties both queues, which read level 0 on the next cycle. Both stay empty and refuse pushes until the cycle after an `abort_clr_i` strobe. Pushes in the strobe cycle itself are refused. When abort and clear arrive together, the abort wins.
- R9: While `enable_i` is low both queues are flushed and refuse pushes, no event pulses, and `eng_stall_o` is low.
- R10: An engine pop from an empty transmit queue is ignored: the level stays 0 and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; low flushes both queues |
| hold_on_full_i | input | 1 | Stall the bus instead of overflowing the receive queue |
| cpu_cmd_wr_i | input | 1 | Processor command write strobe |
| cpu_cmd_i | input | 9 | Command: bit 8 read/write, bits 7:0 data |
| cpu_rd_i | input | 1 | Processor receive read strobe |
| cpu_rd_data_o | output | 8 | Oldest received byte |
| eng_cmd_pop_i | input | 1 | Engine takes the head command |
| eng_cmd_o | output | 9 | Head command |
| eng_cmd_valid_o | output | 1 | Head command is available |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| eng_stall_o | output | 1 | Engine should stall the bus |
| abort_i | input | 1 | Transmit abort |
| abort_clr_i | input | 1 | Abort-clear register read strobe |
| tx_level_o | output | $clog2(DEPTH+1) | Transmit fill level |
| rx_level_o | output | $clog2(DEPTH+1) | Receive fill level |
| rx_under_o | output | 1 | Receive underflow pulse |
| rx_over_o | output | 1 | Receive overflow pulse |
| tx_over_o | output | 1 | Transmit overflow pulse |

## Verification
The bench targets the full boundary. A design that let a 17th entry in would wrap its pointers and overwrite the oldest byte, or report a level of 0. It drives simultaneous push and pop on a full queue, where a design that counted the pop first would accept the byte that should be dropped. It also drives abort together with clear, and pushes in the clear cycle itself. A lock with the wrong priority or an early release would let data in while the queues should read empty. Hold-mode runs show whether a design still raises overflow or computes the stall from the wrong level.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CMD_W  = DATA_W + 1;

  // bit 8: read/write command, bits 7:0: data
  typedef struct packed {
    logic              rd;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic rx_under;
    logic rx_over;
    logic tx_over;
  } evt_t;
endpackage

// File: rtl/i2c_sync_fifo.sv
module i2c_sync_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [LW-1:0]    level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LW-1:0]    level_q;
  logic             push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  // full is judged before any same-cycle pop
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign level_o = level_q;

  a_r3_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_q == '0));
  a_r3_push_pop_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i && !full_o && !empty_o) |=> $stable(level_q));
  a_r7_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (level_q == LW'(DEPTH)));
endmodule

// File: rtl/i2c_flush_ctrl.sv
module i2c_flush_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic abort_i,
  input  logic abort_clr_i,
  output logic flush_o
);
  logic lock_q;

  // abort takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (abort_i) lock_q <= 1'b1;
    else if (abort_clr_i) lock_q <= 1'b0;
  end

  assign flush_o = !enable_i || abort_i || lock_q;

  a_r8_lock_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> flush_o);
  a_r8_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !abort_clr_i) |=> lock_q);
endmodule

// File: rtl/i2c_fifo_events.sv
module i2c_fifo_events
  import i2c_fifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic hold_on_full_i,
  input  logic flush_i,
  input  logic cpu_rd_i,
  input  logic rx_empty_i,
  input  logic rx_push_i,
  input  logic rx_full_i,
  input  logic cpu_wr_i,
  input  logic tx_full_i,
  output evt_t evt_o
);
  evt_t evt_d, evt_q;

  always_comb begin
    evt_d          = '0;
    evt_d.rx_under = enable_i && cpu_rd_i && (rx_empty_i || flush_i);
    evt_d.rx_over  = enable_i && rx_push_i && rx_full_i && !flush_i && !hold_on_full_i;
    evt_d.tx_over  = enable_i && cpu_wr_i && tx_full_i && !flush_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  a_r6_hold_no_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_on_full_i |=> !evt_q.rx_over);
  a_r9_quiet_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (evt_q == '0));
  a_r4_under_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rd_i |=> !evt_q.rx_under);
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
  import i2c_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              hold_on_full_i,
  input  logic              cpu_cmd_wr_i,
  input  logic [CMD_W-1:0]  cpu_cmd_i,
  input  logic              cpu_rd_i,
  output logic [DATA_W-1:0] cpu_rd_data_o,
  input  logic              eng_cmd_pop_i,
  output logic [CMD_W-1:0]  eng_cmd_o,
  output logic              eng_cmd_valid_o,
  input  logic              eng_rx_push_i,
  input  logic [DATA_W-1:0] eng_rx_data_i,
  output logic              eng_stall_o,
  input  logic              abort_i,
  input  logic              abort_clr_i,
  output logic [LW-1:0]     tx_level_o,
  output logic [LW-1:0]     rx_level_o,
  output logic              rx_under_o,
  output logic              rx_over_o,
  output logic              tx_over_o
);
  logic flush;
  logic tx_full, tx_empty, rx_full, rx_empty;
  cmd_t tx_head;
  evt_t evt;

  i2c_flush_ctrl u_flush (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .abort_i     (abort_i),
    .abort_clr_i (abort_clr_i),
    .flush_o     (flush)
  );

  i2c_sync_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (cpu_cmd_wr_i),
    .wdata_i (cpu_cmd_i),
    .pop_i   (eng_cmd_pop_i),
    .rdata_o (tx_head),
    .level_o (tx_level_o),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  i2c_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (cpu_rd_i),
    .rdata_o (cpu_rd_data_o),
    .level_o (rx_level_o),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  i2c_fifo_events u_evt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .enable_i       (enable_i),
    .hold_on_full_i (hold_on_full_i),
    .flush_i        (flush),
    .cpu_rd_i       (cpu_rd_i),
    .rx_empty_i     (rx_empty),
    .rx_push_i      (eng_rx_push_i),
    .rx_full_i      (rx_full),
    .cpu_wr_i       (cpu_cmd_wr_i),
    .tx_full_i      (tx_full),
    .evt_o          (evt)
  );

  assign eng_cmd_o       = tx_head;
  assign eng_cmd_valid_o = !tx_empty && !flush;
  assign eng_stall_o     = enable_i && hold_on_full_i && rx_full;
  assign rx_under_o      = evt.rx_under;
  assign rx_over_o       = evt.rx_over;
  assign tx_over_o       = evt.tx_over;

  a_r2_valid_has_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cmd_valid_o |-> (tx_level_o != '0));
  a_r6_stall_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_stall_o |-> (rx_level_o == LW'(DEPTH)));
  a_r8_abort_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tx_level_o == '0 && rx_level_o == '0));
  a_r7_over_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_over_o |-> $past(cpu_cmd_wr_i));
endmodule

// File: tb/sim_i2c_fifo_pair.sv
`timescale 1ns/1ps
module sim_i2c_fifo_pair;
  localparam int D = 16;
  localparam int LW = $clog2(D + 1);

  logic clk = 0, rst_n = 0;
  logic en = 1, hold = 0, wr = 0, rd = 0, epop = 0, epush = 0, abrt = 0, clr = 0;
  logic [8:0] wcmd = '0;
  logic [7:0] edata = '0;
  logic [7:0] rdata;
  logic [8:0] ecmd;
  logic ecmd_v, stall, r_under, r_over, t_over;
  logic [LW-1:0] tx_lvl, rx_lvl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [8:0] txq[$];
  logic [7:0] rxq[$];
  bit lock_m = 0, under_p = 0, over_p = 0, txover_p = 0;

  always #4 clk = ~clk;

  i2c_fifo_pair #(.DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .hold_on_full_i(hold),
    .cpu_cmd_wr_i(wr), .cpu_cmd_i(wcmd), .cpu_rd_i(rd), .cpu_rd_data_o(rdata),
    .eng_cmd_pop_i(epop), .eng_cmd_o(ecmd), .eng_cmd_valid_o(ecmd_v),
    .eng_rx_push_i(epush), .eng_rx_data_i(edata), .eng_stall_o(stall),
    .abort_i(abrt), .abort_clr_i(clr), .tx_level_o(tx_lvl), .rx_level_o(rx_lvl),
    .rx_under_o(r_under), .rx_over_o(r_over), .tx_over_o(t_over)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    en = 1; wr = 0; rd = 0; epop = 0; epush = 0; abrt = 0; clr = 0;
  endtask

  task automatic compare();
    bit fl;
    fl = !en || abrt || lock_m;
    chk("R3", "tx_level", int'(tx_lvl), txq.size());
    chk("R3", "rx_level", int'(rx_lvl), rxq.size());
    chk("R4", "rx_under", int'(r_under), int'(under_p));
    chk("R5", "rx_over", int'(r_over), int'(over_p));
    chk("R7", "tx_over", int'(t_over), int'(txover_p));
    chk("R6", "stall", int'(stall), int'(en && hold && rxq.size() == D));
    chk("R2", "cmd_valid", int'(ecmd_v), int'(txq.size() > 0 && !fl));
    if (txq.size() > 0) chk("R2", "eng_cmd", int'(ecmd), int'(txq[0]));
    if (rxq.size() > 0) chk("R2", "rd_data", int'(rdata), int'(rxq[0]));
  endtask

  task automatic model_update();
    bit fl, rpop, rpush, tpop, tpush;
    int rs, ts;
    fl = !en || abrt || lock_m;
    rs = rxq.size(); ts = txq.size();
    rpop  = rd && rs > 0 && !fl;
    rpush = epush && rs < D && !fl;
    tpop  = epop && ts > 0 && !fl;
    tpush = wr && ts < D && !fl;
    under_p  = en && rd && !rpop;
    over_p   = en && epush && !fl && rs == D && !hold;
    txover_p = en && wr && !fl && ts == D;
    if (fl) begin
      rxq.delete(); txq.delete();
    end else begin
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(edata);
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(wcmd);
    end
    if (abrt) lock_m = 1;
    else if (clr) lock_m = 0;
  endtask

  task automatic step();
    #1;
    compare();
    model_update();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "tx_level", int'(tx_lvl), 0);
    chk("R1", "rx_level", int'(rx_lvl), 0);
    chk("R1", "events", int'({r_under, r_over, t_over}), 0);
    chk("R1", "stall", int'(stall), 0);
    chk("R1", "cmd_valid", int'(ecmd_v), 0);
    rst_n = 1;
    @(negedge clk);

    // R7 fill transmit queue, then overflow
    for (int i = 0; i < D; i++) begin
      idle(); wr = 1; wcmd = {i[0], 8'(i * 7)}; step();
    end
    idle(); wr = 1; wcmd = 9'h1AA; step();
    idle();
    chk("R7", "tx_over pulse", int'(t_over), 1);
    chk("R7", "tx_level full", int'(tx_lvl), D);
    step();
    chk("R7", "tx_over single", int'(t_over), 0);

    // R2 drain in order
    for (int i = 0; i < D; i++) begin
      idle(); epop = 1; step();
    end
    idle(); epop = 1; step();
    idle();
    chk("R10", "tx_level empty pop", int'(tx_lvl), 0);
    chk("R10", "no event", int'({r_under, r_over, t_over}), 0);

    // R5 overflow receive queue
    for (int i = 0; i < D; i++) begin
      idle(); epush = 1; edata = 8'(i * 13 + 1); step();
    end
    idle(); epush = 1; edata = 8'hEE; step();
    idle();
    chk("R5", "rx_over pulse", int'(r_over), 1);
    chk("R5", "rx_level full", int'(rx_lvl), D);
    chk("R5", "oldest kept", int'(rdata), 1);
    // R5 push+pop on full: push refused
    idle(); epush = 1; edata = 8'h77; rd = 1; step();
    idle();
    chk("R5", "full push+pop level", int'(rx_lvl), D - 1);
    for (int i = 0; i < D - 1; i++) begin
      idle(); rd = 1; step();
    end
    idle(); rd = 1; step();
    idle();
    chk("R4", "rx_under pulse", int'(r_under), 1);
    chk("R4", "rx_level", int'(rx_lvl), 0);

    // R3 simultaneous push and pop
    for (int i = 0; i < 5; i++) begin
      idle(); epush = 1; edata = 8'(40 + i); step();
    end
    idle(); epush = 1; edata = 8'h55; rd = 1; step();
    idle();
    chk("R3", "push+pop keeps level", int'(rx_lvl), 5);

    // R6 hold mode
    hold = 1;
    for (int i = 0; i < D - 5; i++) begin
      idle(); epush = 1; edata = 8'(90 + i); step();
    end
    idle();
    #1 chk("R6", "stall at full", int'(stall), 1);
    epush = 1; edata = 8'h33; step();
    idle();
    chk("R6", "no rx_over", int'(r_over), 0);
    chk("R6", "level stays", int'(rx_lvl), D);
    hold = 0;
    #1 chk("R6", "stall off", int'(stall), 0);

    // R8 abort lock
    for (int i = 0; i < 3; i++) begin
      idle(); wr = 1; wcmd = 9'(i + 5); step();
    end
    idle(); abrt = 1; step();
    idle();
    chk("R8", "tx flushed", int'(tx_lvl), 0);
    chk("R8", "rx flushed", int'(rx_lvl), 0);
    idle(); wr = 1; epush = 1; step();
    idle();
    chk("R8", "locked tx", int'(tx_lvl), 0);
    chk("R8", "locked rx", int'(rx_lvl), 0);
    idle(); clr = 1; wr = 1; wcmd = 9'h101; step();
    idle();
    chk("R8", "clear cycle refuses", int'(tx_lvl), 0);
    idle(); wr = 1; wcmd = 9'h102; step();
    idle();
    chk("R8", "after clear accepts", int'(tx_lvl), 1);
    idle(); abrt = 1; clr = 1; step();
    idle(); wr = 1; step();
    idle();
    chk("R8", "abort beats clear", int'(tx_lvl), 0);
    idle(); clr = 1; step();

    // R9 disable
    for (int i = 0; i < 4; i++) begin
      idle(); epush = 1; wr = 1; step();
    end
    idle(); en = 0; step();
    idle(); en = 0;
    chk("R9", "tx flushed", int'(tx_lvl), 0);
    chk("R9", "rx flushed", int'(rx_lvl), 0);
    hold = 1; rd = 1; wr = 1; epush = 1; step();
    idle(); en = 0;
    chk("R9", "no events", int'({r_under, r_over, t_over}), 0);
    chk("R9", "levels held", int'(tx_lvl) + int'(rx_lvl), 0);
    #1 chk("R9", "stall low", int'(stall), 0);
    hold = 0;
    idle(); step();

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      wr    = ($urandom % 100) < 45;
      wcmd  = 9'($urandom);
      epop  = ($urandom % 100) < 40;
      epush = ($urandom % 100) < 45;
      edata = 8'($urandom);
      rd    = ($urandom % 100) < 40;
      abrt  = ($urandom % 200) == 0;
      clr   = ($urandom % 20) == 0;
      en    = ($urandom % 60) != 0;
      if (($urandom % 100) == 0) hold = ~hold;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule